// File: doc/BRIEF.md
# Noise-Driven Burst Frequency Hop Controller

This block chooses which of three burst timing settings a touch matrix scanner uses. While a scan runs, every key sample delta is compared against a noise threshold. Samples above the threshold raise a positive-noise tally, and samples below its negative raise a negative-noise tally. When a scan ends and both tallies have reached the noise limit, the block moves to the next setting in a fixed rotation. It does not move while calibration is running, and it does not move when hopping is switched off.

Each move is followed by one of two ways of handling key references. The block either raises a one-cycle request to recalibrate every key, or it publishes a signed offset that the reference store adds to each key's reference. That offset comes from two configured calibration differences. One difference relates the first setting to the second, and the other relates the first to the third. A move between the second and third settings uses the combination of both differences. The block does not generate bursts and does not store references.

Top module: `fh_hop_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `freq_sel` is 0 and `hop_pulse`, `recal_req` and `adj_valid` are 0.
- R2: A sample with `sample_valid` high counts as positive noise when `sample_delta` (two's complement) is strictly greater than `noise_thr`, and as negative noise when it is strictly less than minus `noise_thr`. A delta equal to ±`noise_thr`, or any sample with `sample_valid` low, counts for neither.
- R3: A hop happens at a `scan_end` cycle only if both the positive and the negative count have reached `noise_limit`. A large count in one direction alone never causes a hop.
- R4: Both counts return to zero at every `scan_end` cycle, whether or not a hop occurs. A sample presented in the same cycle as `scan_end` is discarded.
- R5: No hop occurs at a `scan_end` cycle in which `cal_active` is high.
- R6: `hop_mode` encoding: 0 means hopping is off, 1 means hop and request recalibration, 2 means hop and adjust references, and 3 behaves as 0. `recal_req` pulses only with a mode-1 hop, and `adj_valid` pulses only with a mode-2 hop.
- R7: Settings rotate 0 → 1 → 2 → 0. `freq_sel` changes only on a hop, and `freq_delay` always equals the delay input of the selected setting (`dly_a`, `dly_b`, `dly_c` for 0, 1, 2).
- R8: `hop_pulse` is high for exactly the one cycle after the clock edge that samples the qualifying `scan_end`. `recal_req` and `adj_valid` are high in that same cycle, and `freq_sel` takes its new value at that same edge.
- R9: With per-setting offsets O0 = 0, O1 = `cal_ofs_b` and O2 = `cal_ofs_c`, the value `ref_offset` shown with `adj_valid` equals O(old) − O(new). The move 0→1 gives −O1, the move 1→2 gives O1 − O2, and the move 2→0 gives +O2.
- R10: A negative `cal_ofs_b` or `cal_ofs_c` (two's complement) is treated as 0 when offsets are formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | A key sample delta is present |
| sample_delta | input | DELTA_W | Signed sample delta (signal minus reference) |
| noise_thr | input | DELTA_W-1 | Noise threshold magnitude |
| noise_limit | input | CNT_W | Count both directions must reach in one scan |
| scan_end | input | 1 | Strobe marking the end of a matrix scan |
| cal_active | input | 1 | Calibration in progress; blocks hopping |
| hop_mode | input | 2 | Reference handling mode (see R6) |
| dly_a | input | DLY_W | Delay value of setting 0 |
| dly_b | input | DLY_W | Delay value of setting 1 |
| dly_c | input | DLY_W | Delay value of setting 2 |
| cal_ofs_b | input | OFS_W | Signed calibrated offset, setting 0 to 1 |
| cal_ofs_c | input | OFS_W | Signed calibrated offset, setting 0 to 2 |
| freq_sel | output | 2 | Index of the current setting |
| freq_delay | output | DLY_W | Delay value of the current setting |
| hop_pulse | output | 1 | One-cycle hop strobe |
| recal_req | output | 1 | One-cycle request to recalibrate all keys |
| adj_valid | output | 1 | One-cycle strobe: `ref_offset` must be applied |
| ref_offset | output | OFS_W+1 | Signed offset to add to every key reference |

## Verification
The hardest case to reach is the 1→2 move, because it is the only move whose offset combines both calibration differences. Reaching it requires two qualifying hops in a row from reset, each in a scan where both directions cross the limit. The stimulus table therefore interleaves qualifying scans with scans that fall one sample short in either direction, scans that land exactly on ±threshold, scans blocked by calibration, and scans with hopping disabled. The rotation passes through 1→2 twice, once with each reference mode. A later directed pass reaches 2 again after a calibration difference has been made negative, so the clamp shows up in the 1→2 and 2→0 offsets.

// File: rtl/fh_pkg.sv
package fh_pkg;

    typedef enum logic [1:0] {
        FREQ_A = 2'd0,
        FREQ_B = 2'd1,
        FREQ_C = 2'd2
    } freq_idx_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_RECAL  = 2'd1,
        ACT_ADJUST = 2'd2
    } hop_act_e;

    typedef struct packed {
        logic neg;
        logic pos;
    } noise_flags_t;

    localparam int NUM_DIR = 2;

    function automatic freq_idx_e next_freq(input freq_idx_e cur);
        case (cur)
            FREQ_A:  return FREQ_B;
            FREQ_B:  return FREQ_C;
            default: return FREQ_A;
        endcase
    endfunction

    function automatic hop_act_e decode_mode(input logic [1:0] mode);
        case (mode)
            2'd1:    return ACT_RECAL;
            2'd2:    return ACT_ADJUST;
            default: return ACT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fh_delta_classify.sv
module fh_delta_classify
    import fh_pkg::*;
#(
    parameter int DELTA_W = 16
) (
    input  logic [DELTA_W-1:0] delta,
    input  logic [DELTA_W-2:0] thr,
    output noise_flags_t       flags
);
    localparam int EXT_W = DELTA_W + 1;

    logic signed [EXT_W-1:0] d_ext;
    logic signed [EXT_W-1:0] t_pos;
    logic signed [EXT_W-1:0] t_neg;

    always_comb begin
        d_ext     = $signed({delta[DELTA_W-1], delta});
        t_pos     = $signed({2'b00, thr});
        t_neg     = -t_pos;
        flags.pos = (d_ext > t_pos);
        flags.neg = (d_ext < t_neg);
    end
endmodule

// File: rtl/fh_noise_counter.sv
module fh_noise_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             reached
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

    assign reached = (count >= limit);
endmodule

// File: rtl/fh_hop_decider.sv
module fh_hop_decider
    import fh_pkg::*;
(
    input  logic       scan_end,
    input  logic       pos_reached,
    input  logic       neg_reached,
    input  logic       cal_active,
    input  logic [1:0] mode,
    input  freq_idx_e  cur,
    output logic       do_hop,
    output hop_act_e   act,
    output freq_idx_e  nxt
);
    always_comb begin
        act    = decode_mode(mode);
        nxt    = next_freq(cur);
        do_hop = scan_end && pos_reached && neg_reached
                 && !cal_active && (act != ACT_NONE);
    end
endmodule

// File: rtl/fh_ref_offset.sv
module fh_ref_offset
    import fh_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  freq_idx_e          from_f,
    input  freq_idx_e          to_f,
    input  logic [OFS_W-1:0]   ofs_b,
    input  logic [OFS_W-1:0]   ofs_c,
    output logic [OFS_W:0]     ofs_out
);
    logic [OFS_W-1:0] mag_b;
    logic [OFS_W-1:0] mag_c;
    logic [OFS_W-1:0] o_from;
    logic [OFS_W-1:0] o_to;

    always_comb begin
        mag_b = ofs_b[OFS_W-1] ? '0 : ofs_b;
        mag_c = ofs_c[OFS_W-1] ? '0 : ofs_c;
        case (from_f)
            FREQ_B:  o_from = mag_b;
            FREQ_C:  o_from = mag_c;
            default: o_from = '0;
        endcase
        case (to_f)
            FREQ_B:  o_to = mag_b;
            FREQ_C:  o_to = mag_c;
            default: o_to = '0;
        endcase
        ofs_out = {1'b0, o_from} - {1'b0, o_to};
    end
endmodule

// File: rtl/fh_hop_ctrl.sv
module fh_hop_ctrl
    import fh_pkg::*;
#(
    parameter int DELTA_W = 16,
    parameter int CNT_W   = 8,
    parameter int DLY_W   = 6,
    parameter int OFS_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_valid,
    input  logic [DELTA_W-1:0] sample_delta,
    input  logic [DELTA_W-2:0] noise_thr,
    input  logic [CNT_W-1:0]   noise_limit,
    input  logic               scan_end,
    input  logic               cal_active,
    input  logic [1:0]         hop_mode,
    input  logic [DLY_W-1:0]   dly_a,
    input  logic [DLY_W-1:0]   dly_b,
    input  logic [DLY_W-1:0]   dly_c,
    input  logic [OFS_W-1:0]   cal_ofs_b,
    input  logic [OFS_W-1:0]   cal_ofs_c,
    output logic [1:0]         freq_sel,
    output logic [DLY_W-1:0]   freq_delay,
    output logic               hop_pulse,
    output logic               recal_req,
    output logic               adj_valid,
    output logic [OFS_W:0]     ref_offset
);
    noise_flags_t       flags;
    logic [NUM_DIR-1:0] dir_hit;
    logic [NUM_DIR-1:0] dir_reached;
    freq_idx_e          cur_f;
    freq_idx_e          nxt_f;
    hop_act_e           act;
    logic               do_hop;
    logic [OFS_W:0]     ofs_calc;

    fh_delta_classify #(.DELTA_W(DELTA_W)) u_class (
        .delta (sample_delta),
        .thr   (noise_thr),
        .flags (flags)
    );

    assign dir_hit = {flags.neg, flags.pos};

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        fh_noise_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .clr     (scan_end),
            .inc     (sample_valid && dir_hit[d]),
            .limit   (noise_limit),
            .reached (dir_reached[d])
        );
    end

    fh_hop_decider u_dec (
        .scan_end    (scan_end),
        .pos_reached (dir_reached[0]),
        .neg_reached (dir_reached[1]),
        .cal_active  (cal_active),
        .mode        (hop_mode),
        .cur         (cur_f),
        .do_hop      (do_hop),
        .act         (act),
        .nxt         (nxt_f)
    );

    fh_ref_offset #(.OFS_W(OFS_W)) u_ofs (
        .from_f  (cur_f),
        .to_f    (nxt_f),
        .ofs_b   (cal_ofs_b),
        .ofs_c   (cal_ofs_c),
        .ofs_out (ofs_calc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_f      <= FREQ_A;
            hop_pulse  <= 1'b0;
            recal_req  <= 1'b0;
            adj_valid  <= 1'b0;
            ref_offset <= '0;
        end else begin
            hop_pulse <= do_hop;
            recal_req <= do_hop && (act == ACT_RECAL);
            adj_valid <= do_hop && (act == ACT_ADJUST);
            if (do_hop) begin
                cur_f      <= nxt_f;
                ref_offset <= ofs_calc;
            end
        end
    end

    always_comb begin
        case (cur_f)
            FREQ_B:  freq_delay = dly_b;
            FREQ_C:  freq_delay = dly_c;
            default: freq_delay = dly_a;
        endcase
    end

    assign freq_sel = cur_f;
endmodule

// File: rtl/fh_hop_ctrl_chk.sv
module fh_hop_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       scan_end,
    input logic       cal_active,
    input logic [1:0] hop_mode,
    input logic [1:0] freq_sel,
    input logic       hop_pulse,
    input logic       recal_req,
    input logic       adj_valid
);
    AST_HOP_AFTER_SCAN_END: assert property (@(posedge clk) disable iff (rst)
        hop_pulse |-> $past(scan_end)); // R8

    AST_NO_HOP_IN_CAL: assert property (@(posedge clk) disable iff (rst)
        hop_pulse |-> !$past(cal_active)); // R5

    AST_MODE_ALLOWS_HOP: assert property (@(posedge clk) disable iff (rst)
        hop_pulse |-> ($past(hop_mode) == 2'd1 || $past(hop_mode) == 2'd2)); // R6

    AST_RECAL_WITH_HOP: assert property (@(posedge clk) disable iff (rst)
        recal_req |-> (hop_pulse && $past(hop_mode) == 2'd1)); // R6

    AST_ADJ_WITH_HOP: assert property (@(posedge clk) disable iff (rst)
        adj_valid |-> (hop_pulse && $past(hop_mode) == 2'd2)); // R6

    AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hop_pulse |-> $stable(freq_sel)); // R7

    AST_FREQ_ROTATE: assert property (@(posedge clk) disable iff (rst)
        hop_pulse |-> (freq_sel == (($past(freq_sel) == 2'd2) ? 2'd0 : $past(freq_sel) + 2'd1))); // R7

    AST_FREQ_RANGE: assert property (@(posedge clk) disable iff (rst)
        freq_sel != 2'd3); // R7
endmodule

bind fh_hop_ctrl fh_hop_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scan_end   (scan_end),
    .cal_active (cal_active),
    .hop_mode   (hop_mode),
    .freq_sel   (freq_sel),
    .hop_pulse  (hop_pulse),
    .recal_req  (recal_req),
    .adj_valid  (adj_valid)
);

// File: tb/fh_hop_ctrl_test.sv
module fh_hop_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DELTA_W = 16;
    localparam int CNT_W   = 8;
    localparam int DLY_W   = 6;
    localparam int OFS_W   = 16;
    localparam int THR     = 10;
    localparam int LIMIT   = 3;
    localparam int NVEC    = 12;

    // {npos, nneg, mode, cal, expect_hop}
    localparam logic [11:0] VEC [NVEC] = '{
        {4'd3, 4'd3, 2'd2, 1'b0, 1'b1},
        {4'd5, 4'd4, 2'd1, 1'b0, 1'b1},
        {4'd3, 4'd2, 2'd2, 1'b0, 1'b0},
        {4'd2, 4'd3, 2'd2, 1'b0, 1'b0},
        {4'd4, 4'd4, 2'd2, 1'b1, 1'b0},
        {4'd4, 4'd4, 2'd0, 1'b0, 1'b0},
        {4'd4, 4'd4, 2'd3, 1'b0, 1'b0},
        {4'd3, 4'd3, 2'd2, 1'b0, 1'b1},
        {4'd6, 4'd3, 2'd1, 1'b0, 1'b1},
        {4'd0, 4'd9, 2'd2, 1'b0, 1'b0},
        {4'd3, 4'd3, 2'd2, 1'b0, 1'b1},
        {4'd3, 4'd3, 2'd2, 1'b0, 1'b1}
    };

    logic               clk = 1'b0;
    logic               rst;
    logic               sample_valid;
    logic [DELTA_W-1:0] sample_delta;
    logic [DELTA_W-2:0] noise_thr;
    logic [CNT_W-1:0]   noise_limit;
    logic               scan_end;
    logic               cal_active;
    logic [1:0]         hop_mode;
    logic [DLY_W-1:0]   dly_a, dly_b, dly_c;
    logic [OFS_W-1:0]   cal_ofs_b, cal_ofs_c;
    logic [1:0]         freq_sel;
    logic [DLY_W-1:0]   freq_delay;
    logic               hop_pulse, recal_req, adj_valid;
    logic [OFS_W:0]     ref_offset;

    int n_checks = 0;
    int n_fail   = 0;
    int model_f  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fh_hop_ctrl #(.DELTA_W(DELTA_W), .CNT_W(CNT_W), .DLY_W(DLY_W), .OFS_W(OFS_W)) uut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_delta(sample_delta),
        .noise_thr(noise_thr), .noise_limit(noise_limit), .scan_end(scan_end),
        .cal_active(cal_active), .hop_mode(hop_mode), .dly_a(dly_a), .dly_b(dly_b),
        .dly_c(dly_c), .cal_ofs_b(cal_ofs_b), .cal_ofs_c(cal_ofs_c), .freq_sel(freq_sel),
        .freq_delay(freq_delay), .hop_pulse(hop_pulse), .recal_req(recal_req),
        .adj_valid(adj_valid), .ref_offset(ref_offset)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ofs_of(input int f);
        int b = $signed(cal_ofs_b);
        int c = $signed(cal_ofs_c);
        if (b < 0) b = 0;
        if (c < 0) c = 0;
        return (f == 1) ? b : (f == 2) ? c : 0;
    endfunction

    function automatic int dly_of(input int f);
        return (f == 1) ? int'(dly_b) : (f == 2) ? int'(dly_c) : int'(dly_a);
    endfunction

    task automatic give(input int d);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_delta = DELTA_W'(d);
    endtask

    // end a scan, check outputs in the cycle after the edge, then check strobe drop
    task automatic finish_scan(input bit exp_hop, input int mode, input bit extra_sample);
        int old_f;
        int exp_ofs;
        @(negedge clk);
        sample_valid = extra_sample;
        sample_delta = DELTA_W'(-(THR + 5));
        scan_end = 1'b1;
        old_f = model_f;
        @(negedge clk);
        scan_end = 1'b0;
        sample_valid = 1'b0;
        if (exp_hop) model_f = (model_f + 1) % 3;
        exp_ofs = ofs_of(old_f) - ofs_of(model_f);
        chk("R3 hop_pulse", int'(hop_pulse), int'(exp_hop));
        chk("R7 freq_sel", int'(freq_sel), model_f);
        chk("R7 freq_delay", int'(freq_delay), dly_of(model_f));
        chk("R6 recal_req", int'(recal_req), int'(exp_hop && mode == 1));
        chk("R6 adj_valid", int'(adj_valid), int'(exp_hop && mode == 2));
        if (exp_hop && mode == 2)
            chk("R9 ref_offset", int'($signed(ref_offset)), exp_ofs);
        @(negedge clk);
        chk("R8 hop_pulse one cycle", int'(hop_pulse), 0);
        chk("R8 recal/adj one cycle", int'(recal_req | adj_valid), 0);
    endtask

    task automatic run_scan(input int np, input int nn, input bit with_edges);
        for (int i = 0; i < 10; i++) begin
            if (i < np) give(THR + 1 + i);
            if (i < nn) give(-(THR + 1 + i));
        end
        if (with_edges) begin
            give(THR);          // R2: equal to threshold, not counted
            give(-THR);
            give(THR);
            @(negedge clk);     // R2: large delta without valid
            sample_valid = 1'b0;
            sample_delta = DELTA_W'(THR + 50);
        end
    endtask

    initial begin
        rst = 1'b1; sample_valid = 1'b0; sample_delta = '0; scan_end = 1'b0;
        cal_active = 1'b0; hop_mode = 2'd2;
        noise_thr = (DELTA_W-1)'(THR); noise_limit = CNT_W'(LIMIT);
        dly_a = 6'd24; dly_b = 6'd30; dly_c = 6'd36;
        cal_ofs_b = OFS_W'(40); cal_ofs_c = OFS_W'(100);
        repeat (3) @(negedge clk);
        chk("R1 reset freq_sel", int'(freq_sel), 0);
        chk("R1 reset strobes", int'(hop_pulse | recal_req | adj_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset freq_delay", int'(freq_delay), 24);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            hop_mode   = VEC[v][3:2];
            cal_active = VEC[v][1];
            run_scan(int'(VEC[v][11:8]), int'(VEC[v][7:4]), 1'b1);
            finish_scan(VEC[v][0], int'(VEC[v][3:2]), 1'b0);
            cal_active = 1'b0;
        end

        // R4: counts cleared between scans (2+2 twice does not add up)
        hop_mode = 2'd2;
        run_scan(2, 2, 1'b0);
        finish_scan(1'b0, 2, 1'b0);
        run_scan(2, 2, 1'b0);
        finish_scan(1'b0, 2, 1'b0);

        // R4: sample coincident with scan_end discarded (would be third negative)
        run_scan(3, 2, 1'b0);
        finish_scan(1'b0, 2, 1'b1);

        // R10: negative calibrated offset clamps to zero
        cal_ofs_c = OFS_W'(-5);
        run_scan(3, 3, 1'b0);
        finish_scan(1'b1, 2, 1'b0);   // 0->1: -40
        run_scan(3, 3, 1'b0);
        finish_scan(1'b1, 2, 1'b0);   // 1->2: R10 gives 40
        run_scan(3, 3, 1'b0);
        finish_scan(1'b1, 2, 1'b0);   // 2->0: R10 gives 0

        // R1: reset mid-run returns to setting 0
        run_scan(3, 3, 1'b0);
        finish_scan(1'b1, 2, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_f = 0;
        chk("R1 reset mid-run freq_sel", int'(freq_sel), 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule